// File: doc/BRIEF.md
# Multi-Block Erase Sequencer With Lock Masking

This block erases a set of memory blocks one at a time. The memory is divided into a low/mid address space (blocks `0` to `NLM-1`), a high address space (blocks `NLM` to `NLM+NHI-1`) and one shadow row. The shadow row is block index `NLM+NHI`, which is 8 with the default parameters. Software raises the erase-mode input, writes the select vectors, and then enables high voltage. The sequencer then combines the select vectors with the lock vectors and visits the eligible blocks in ascending index order. For each block it issues an erase request to a modelled array, and the array sets every bit of that block to 1.

Each block erase takes a programmable number of cycles. When the sequence ends, `done` goes high and stays high until erase mode is dropped. An abort stops the walk at once. The abort flags the block in progress, and every eligible block not yet reached, as indeterminate. That flag clears when a later erase of the block completes. A small program port clears bits in the array, and a read port returns the content of any block. The bench uses these two ports to see the effect of an erase.

The controller has five states:
- `ST_IDLE` waits for a rising edge on `ers_mode`.
- `ST_ARMED` waits for `hv_en`.
- `ST_SEEK` picks the lowest pending block.
- `ST_ERASE` counts the erase time of the current block.
- `ST_DONE` holds `done`.

The transitions are:
- IDLE→ARMED on a rising edge of `ers_mode`.
- ARMED→IDLE when `ers_mode` is low.
- ARMED→SEEK when `hv_en` is high and at least one block is eligible.
- ARMED→DONE when `hv_en` is high and no block is eligible.
- SEEK→ERASE when a block is pending.
- SEEK→DONE when nothing is pending or `abort` is high.
- ERASE→SEEK when the erase time of the block has elapsed.
- ERASE→DONE on `abort`.
- DONE→IDLE when `ers_mode` is low.

Top module: `blk_erase_seq`

## Requirements
- R1: A completed block erase sets all `DW` bits of that block to 1, as read on `rd_data`. Blocks that are not erased keep their content.
- R2: The eligible set is computed as follows. A low/mid block `i` is eligible when `sel_lm[i] & ~(lock_lm_a[i] | lock_lm_b[i])`. A high block `NLM+j` is eligible when `sel_hi[j] & ~lock_hi[j]`. A selected block that is locked is never erased.
- R3: Eligible blocks are erased one after another in strictly ascending block index. `ers_blk` shows the block index while `ers_active` is high.
- R4: A sequence is armed only by a 0→1 edge of `ers_mode`. The selects and locks are sampled in the first ARMED cycle in which `hv_en` is high. With `ers_mode` held high and no new edge, raising `hv_en` again in DONE starts nothing. Dropping `ers_mode` returns the block to idle.
- R5: When `shadow_sel` is high at the start of a sequence, the select vectors are ignored and only the shadow row (block index `NLM+NHI`) is erased.
- R6: An `abort` during SEEK or ERASE ends the sequence. The block in progress is not written, and it is flagged in `indet` together with every eligible block not yet erased. `done` is high in the following cycle. Bit `k` of `indet` belongs to block `k`.
- R7: A later completed erase of a block clears its `indet` bit.
- R8: `ers_active` stays high for `erase_cycles` cycles per block, with 0 treated as 1. `done` rises one cycle after `ers_active` falls for the last block. When no block is eligible, `done` rises in the cycle right after `hv_en` is seen in ARMED.
- R9: After reset, `done`, `ers_active` and `indet` are 0, and every block reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ers_mode | input | 1 | Erase mode; a rising edge arms a sequence |
| hv_en | input | 1 | High-voltage enable; starts an armed sequence |
| abort | input | 1 | Stops a running sequence |
| shadow_sel | input | 1 | Erase only the shadow row |
| sel_lm | input | NLM | Low/mid block select |
| sel_hi | input | NHI | High block select |
| lock_lm_a | input | NLM | Primary low/mid lock |
| lock_lm_b | input | NLM | Secondary low/mid lock |
| lock_hi | input | NHI | High-space lock |
| erase_cycles | input | CW | Cycles per block erase |
| prog_en | input | 1 | Program strobe (AND into block) |
| prog_blk | input | IW | Block index to program |
| prog_data | input | DW | Program data |
| rd_blk | input | IW | Block index to read |
| rd_data | output | DW | Content of block `rd_blk` |
| done | output | 1 | Sequence finished |
| ers_active | output | 1 | A block erase is in progress |
| ers_blk | output | IW | Index of the block being erased |
| indet | output | NLM+NHI+1 | Indeterminate flag per block |

## Verification
The hardest situation to reach from the ports is an abort that falls in the middle of a walk. At that point one block has finished, one is in progress and others are still pending, so all three groups must be told apart in `indet` and in the array content. The bench sets a long erase time and selects four blocks. It watches `ers_blk` at each falling edge and pulses `abort` only after the second block has been active for two cycles. A second sequence then re-erases part of the aborted set, which shows that the flags clear only for the blocks that were actually erased.

// File: rtl/blk_ers_pkg.sv
package blk_ers_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SEEK,
        ST_ERASE,
        ST_DONE
    } ers_state_t;
endpackage

// File: rtl/ers_mask.sv
module ers_mask #(
    parameter int NLM = 4,
    parameter int NHI = 4,
    localparam int NT = NLM + NHI + 1
) (
    input  logic [NLM-1:0] sel_lm,
    input  logic [NHI-1:0] sel_hi,
    input  logic [NLM-1:0] lock_lm_a,
    input  logic [NLM-1:0] lock_lm_b,
    input  logic [NHI-1:0] lock_hi,
    input  logic           shadow_sel,
    output logic [NT-1:0]  mask
);
    always_comb begin
        if (shadow_sel) begin
            mask         = '0;
            mask[NT-1]   = 1'b1;
        end else begin
            mask = {1'b0, sel_hi & ~lock_hi, sel_lm & ~(lock_lm_a | lock_lm_b)};
        end
    end
endmodule

// File: rtl/ers_pick.sv
module ers_pick #(
    parameter int N  = 9,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Lowest set index wins: scan downward so the last hit is the lowest.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ers_array.sv
module ers_array #(
    parameter int NT = 9,
    parameter int DW = 8,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ers_we,
    input  logic [IW-1:0] ers_idx,
    input  logic          prog_en,
    input  logic [IW-1:0] prog_idx,
    input  logic [DW-1:0] prog_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [NT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NT; i++) mem[i] <= '0;
        end else begin
            if (ers_we && int'(ers_idx) < NT)
                mem[ers_idx] <= '1;
            if (prog_en && int'(prog_idx) < NT && !(ers_we && prog_idx == ers_idx))
                mem[prog_idx] <= mem[prog_idx] & prog_data;
        end
    end

    assign rd_data = (int'(rd_idx) < NT) ? mem[rd_idx] : '0;

    // Checker: the block named by the last erase request holds all ones.
    logic          chk_we;
    logic [IW-1:0] chk_idx;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_we  <= 1'b0;
            chk_idx <= '0;
        end else begin
            chk_we  <= ers_we && int'(ers_idx) < NT;
            chk_idx <= ers_idx;
        end
    end

    assert_erased_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        chk_we |-> mem[chk_idx] == '1);
endmodule

// File: rtl/blk_erase_seq.sv
module blk_erase_seq
    import blk_ers_pkg::*;
#(
    parameter int NLM = 4,
    parameter int NHI = 4,
    parameter int DW  = 8,
    parameter int CW  = 8,
    localparam int NB = NLM + NHI,
    localparam int NT = NB + 1,
    localparam int IW = $clog2(NT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ers_mode,
    input  logic          hv_en,
    input  logic          abort,
    input  logic          shadow_sel,
    input  logic [NLM-1:0] sel_lm,
    input  logic [NHI-1:0] sel_hi,
    input  logic [NLM-1:0] lock_lm_a,
    input  logic [NLM-1:0] lock_lm_b,
    input  logic [NHI-1:0] lock_hi,
    input  logic [CW-1:0] erase_cycles,
    input  logic          prog_en,
    input  logic [IW-1:0] prog_blk,
    input  logic [DW-1:0] prog_data,
    input  logic [IW-1:0] rd_blk,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic          ers_active,
    output logic [IW-1:0] ers_blk,
    output logic [NT-1:0] indet
);
    ers_state_t    state, nstate;
    logic          ers_q;
    logic [NT-1:0] pend;
    logic [NT-1:0] indet_q;
    logic [IW-1:0] cur;
    logic [CW-1:0] cnt;
    logic [NT-1:0] mask;
    logic [IW-1:0] pick_idx;
    logic          pick_any;
    logic          last;
    logic          ers_we;
    logic [CW:0]   cnt_nxt;

    ers_mask #(.NLM(NLM), .NHI(NHI)) i_mask (
        .sel_lm(sel_lm), .sel_hi(sel_hi), .lock_lm_a(lock_lm_a),
        .lock_lm_b(lock_lm_b), .lock_hi(lock_hi), .shadow_sel(shadow_sel),
        .mask(mask)
    );

    ers_pick #(.N(NT), .IW(IW)) i_pick (
        .vec(pend), .idx(pick_idx), .any(pick_any)
    );

    ers_array #(.NT(NT), .DW(DW), .IW(IW)) i_array (
        .clk(clk), .rst_n(rst_n), .ers_we(ers_we), .ers_idx(cur),
        .prog_en(prog_en), .prog_idx(prog_blk), .prog_data(prog_data),
        .rd_idx(rd_blk), .rd_data(rd_data)
    );

    // A count of zero finishes after one cycle, like a count of one.
    assign cnt_nxt = {1'b0, cnt} + (CW+1)'(1);
    assign last    = cnt_nxt >= {1'b0, erase_cycles};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (ers_mode && !ers_q) nstate = ST_ARMED;
            ST_ARMED: begin
                if (!ers_mode)  nstate = ST_IDLE;
                else if (hv_en) nstate = (|mask) ? ST_SEEK : ST_DONE;
            end
            ST_SEEK:  begin
                if (abort || !pick_any) nstate = ST_DONE;
                else                    nstate = ST_ERASE;
            end
            ST_ERASE: begin
                if (abort)     nstate = ST_DONE;
                else if (last) nstate = ST_SEEK;
            end
            ST_DONE:  if (!ers_mode) nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    // Sequencing data: pending set, current block, counter, flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ers_q   <= 1'b0;
            pend    <= '0;
            indet_q <= '0;
            cur     <= '0;
            cnt     <= '0;
        end else begin
            ers_q <= ers_mode;
            unique case (state)
                ST_ARMED: if (ers_mode && hv_en) pend <= mask;
                ST_SEEK: begin
                    if (abort) begin
                        indet_q <= indet_q | pend;
                        pend    <= '0;
                    end else if (pick_any) begin
                        cur <= pick_idx;
                        cnt <= '0;
                    end
                end
                ST_ERASE: begin
                    if (abort) begin
                        indet_q <= indet_q | pend;
                        pend    <= '0;
                    end else if (last) begin
                        pend[cur]    <= 1'b0;
                        indet_q[cur] <= 1'b0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        done       = (state == ST_DONE);
        ers_active = (state == ST_ERASE);
        ers_we     = (state == ST_ERASE) && !abort && last;
        ers_blk    = cur;
        indet      = indet_q;
    end

    // Checker state: raw inputs captured at sequence start
    logic [NT-1:0] sel_snap, lock_snap, cur_hot;
    logic          shadow_snap;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_snap    <= '0;
            lock_snap   <= '0;
            shadow_snap <= 1'b0;
        end else if (state == ST_ARMED && ers_mode && hv_en) begin
            sel_snap    <= {1'b0, sel_hi, sel_lm};
            lock_snap   <= {1'b0, lock_hi, lock_lm_a | lock_lm_b};
            shadow_snap <= shadow_sel;
        end
    end
    assign cur_hot = NT'(1) << cur;

    assert_lock_honoured_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ers_active && !shadow_snap) |-> ((sel_snap & cur_hot) != '0 && (lock_snap & cur_hot) == '0));

    assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ers_active |-> ((pend & (cur_hot - NT'(1))) == '0 && (pend & cur_hot) != '0));

    assert_shadow_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ers_active && shadow_snap) |-> cur == IW'(NB));

    assert_abort_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ERASE || state == ST_SEEK) && abort) |=> (done && (indet & $past(pend)) == $past(pend)));

    assert_flag_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ers_we |=> (indet & $past(cur_hot)) == '0);

    assert_done_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pend == '0);
endmodule

// File: tb/test_blk_erase_seq.sv
`timescale 1ns/1ps
module test_blk_erase_seq;
    localparam int NLM = 4, NHI = 4, DW = 8, CW = 8;
    localparam int NT = NLM + NHI + 1, IW = 4;

    logic clk = 0, rst_n = 0;
    logic ers_mode = 0, hv_en = 0, abort = 0, shadow_sel = 0;
    logic [NLM-1:0] sel_lm = '0, lock_lm_a = '0, lock_lm_b = '0;
    logic [NHI-1:0] sel_hi = '0, lock_hi = '0;
    logic [CW-1:0]  erase_cycles = 8'd1;
    logic prog_en = 0;
    logic [IW-1:0] prog_blk = '0, rd_blk = '0;
    logic [DW-1:0] prog_data = '0;
    logic [DW-1:0] rd_data;
    logic done, ers_active;
    logic [IW-1:0] ers_blk;
    logic [NT-1:0] indet;

    int nchk = 0, nfail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    blk_erase_seq i_blk_erase_seq (
        .clk(clk), .rst_n(rst_n), .ers_mode(ers_mode), .hv_en(hv_en), .abort(abort),
        .shadow_sel(shadow_sel), .sel_lm(sel_lm), .sel_hi(sel_hi),
        .lock_lm_a(lock_lm_a), .lock_lm_b(lock_lm_b), .lock_hi(lock_hi),
        .erase_cycles(erase_cycles), .prog_en(prog_en), .prog_blk(prog_blk),
        .prog_data(prog_data), .rd_blk(rd_blk), .rd_data(rd_data), .done(done),
        .ers_active(ers_active), .ers_blk(ers_blk), .indet(indet)
    );

    // {sel_lm, sel_hi, lock_a, lock_b, lock_hi, shadow, cycles, expected erase set}
    localparam logic [37:0] VEC [6] = '{
        {4'b1011, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 8'd3, 9'h00B},
        {4'b1111, 4'b1111, 4'b0001, 4'b0100, 4'b1000, 1'b0, 8'd2, 9'h07A},
        {4'b0000, 4'b0101, 4'b0000, 4'b0000, 4'b0000, 1'b0, 8'd1, 9'h050},
        {4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b1, 8'd4, 9'h100},
        {4'b1111, 4'b1111, 4'b1010, 4'b0101, 4'b1111, 1'b0, 8'd2, 9'h000},
        {4'b0110, 4'b1001, 4'b0000, 4'b0110, 4'b0001, 1'b0, 8'd0, 9'h080}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_blk(input int b, input logic [DW-1:0] exp, input string req);
        rd_blk = IW'(b);
        #1;
        chk(rd_data === exp, req, int'(rd_data), int'(exp));
    endtask

    task automatic clear_all();
        for (int b = 0; b < NT; b++) begin
            @(negedge clk);
            prog_en = 1; prog_blk = IW'(b); prog_data = '0;
        end
        @(negedge clk);
        prog_en = 0;
    endtask

    task automatic release_mode();
        @(negedge clk);
        ers_mode = 0; hv_en = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Starts a sequence and watches it until done; ers_mode left high.
    task automatic run_seq(input logic [NT-1:0] exp_set, input logic [CW-1:0] cyc, input string tag);
        int ord[NT];
        int n = 0, len = 0, gap = 0, exp_len, j;
        bit prev = 0, len_bad = 0, seen_done = 0;
        exp_len = (cyc == 0) ? 1 : int'(cyc);
        @(negedge clk);
        ers_mode = 1; hv_en = 0;
        @(negedge clk);
        hv_en = 1;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (ers_active && !prev) begin
                if (n < NT) ord[n] = int'(ers_blk);
                n++;
                len = 1;
            end else if (ers_active) begin
                len++;
            end
            if (!ers_active && prev && len != exp_len) len_bad = 1;
            if (ers_active) gap = 0;
            else if (!done) gap++;
            prev = ers_active;
            if (done) begin seen_done = 1; break; end
        end
        hv_en = 0;
        chk(seen_done, {"R8 done reached ", tag}, int'(seen_done), 1);
        chk(gap == ((exp_set != 0) ? 1 : 0), {"R8 done latency ", tag}, gap, (exp_set != 0) ? 1 : 0);
        chk(!len_bad, {"R8 per-block erase length ", tag}, len, exp_len);
        chk(n == $countones(exp_set), {"R2 erase count ", tag}, n, $countones(exp_set));
        j = 0;
        for (int b = 0; b < NT; b++) begin
            if (exp_set[b]) begin
                if (j < n && j < NT) chk(ord[j] == b, {"R3 erase order ", tag}, ord[j], b);
                j++;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(done == 0, "R9 reset done", int'(done), 0);
        chk(ers_active == 0, "R9 reset active", int'(ers_active), 0);
        chk(indet == '0, "R9 reset indet", int'(indet), 0);
        chk_blk(0, 8'h00, "R9 reset block 0");
        chk_blk(8, 8'h00, "R9 reset shadow");
        rst_n = 1;
        @(negedge clk);

        // Vector table: R1 R2 R3 R5 R8
        for (int v = 0; v < 6; v++) begin
            logic [37:0] e;
            e = VEC[v];
            clear_all();
            sel_lm = e[37:34]; sel_hi = e[33:30]; lock_lm_a = e[29:26];
            lock_lm_b = e[25:22]; lock_hi = e[21:18]; shadow_sel = e[17];
            erase_cycles = e[16:9];
            run_seq(e[8:0], e[16:9], $sformatf("vec%0d", v));
            for (int b = 0; b < NT; b++)
                chk_blk(b, e[b] ? 8'hFF : 8'h00, $sformatf("R1 R2 R5 content vec%0d blk%0d", v, b));
            chk(indet == '0, "R6 no flag without abort", int'(indet), 0);
            if (v == 0) begin
                // R4: a second hv_en with ers_mode still high starts nothing
                clear_all();
                @(negedge clk); hv_en = 1;
                repeat (6) begin
                    @(negedge clk);
                    chk(!ers_active && done, "R4 no restart without edge", int'(ers_active), 0);
                end
                hv_en = 0;
                chk_blk(0, 8'h00, "R4 block untouched after re-enable");
            end
            release_mode();
            chk(done == 0, "R4 idle after mode drop", int'(done), 0);
        end
        shadow_sel = 0; lock_lm_a = '0; lock_lm_b = '0; lock_hi = '0; sel_hi = '0;

        // R4: armed without hv_en does nothing
        clear_all();
        sel_lm = 4'b0001; erase_cycles = 8'd2;
        @(negedge clk); ers_mode = 1;
        repeat (5) begin
            @(negedge clk);
            chk(!ers_active && !done, "R4 wait for hv_en", int'(ers_active), 0);
        end
        release_mode();

        // R6: abort during the second of four blocks
        clear_all();
        sel_lm = 4'b1111; erase_cycles = 8'd5;
        @(negedge clk); ers_mode = 1;
        @(negedge clk); hv_en = 1;
        begin
            int seen = 0;
            for (int k = 0; k < 200 && seen < 2; k++) begin
                @(negedge clk);
                if (ers_active && ers_blk == 1) seen++;
            end
        end
        abort = 1;
        @(negedge clk);
        abort = 0; hv_en = 0;
        chk(done == 1, "R6 done after abort", int'(done), 1);
        chk(indet == 9'h00E, "R6 indet flags", int'(indet), 'h00E);
        chk_blk(0, 8'hFF, "R6 finished block kept");
        chk_blk(1, 8'h00, "R6 aborted block not written");
        chk_blk(3, 8'h00, "R6 pending block not written");
        release_mode();

        // R7: re-erase blocks 1 and 2 clears their flags only
        sel_lm = 4'b0110; erase_cycles = 8'd2;
        run_seq(9'h006, 8'd2, "R7 recover");
        chk(indet == 9'h008, "R7 flags after recovery", int'(indet), 'h008);
        chk_blk(1, 8'hFF, "R7 block1 recovered");
        chk_blk(2, 8'hFF, "R7 block2 recovered");
        chk_blk(3, 8'h00, "R7 block3 still unerased");
        release_mode();

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule